// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-programmed master for the two-wire management bus that reaches PHY configuration registers. Software fills in a command word at byte offset 0x0 (frame type, opcode, port address, register or device address, and a 16-bit payload) with the launch bit set. The block then clocks out one complete 64-bit frame on the management data line, generates the management clock itself, and clears the launch bit when the frame ends. Software therefore polls that bit as a busy flag.

A second register at offset 0x4 returns the last captured read data and an idle flag. It also holds three timing settings: the clock-divider threshold, the edge on which the master changes its drive, and a delay in system clocks applied when sampling returned data. Both the short-frame type (start code 01) and the extended-addressing type (start code 00) are handled. An extended-addressing access takes two launches: first an address frame that carries the 16-bit register address, then a read, post-read-increment or write frame to the same port and device.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control register reads 0x0000_0000 and the data/status register reads 0x0401_0000: threshold 4, drive-edge bit 0, delay 0, idle flag (bit 16) set, read data 0.
- R2: A write to offset 0x0 with bit 31 set, made while idle, launches a frame. Bit 31 reads 1 until the frame ends. The frame lasts exactly 128×(T+1) system clocks, where T is the threshold field. The management clock toggles every T+1 clocks, and the first poll that sees bit 31 clear comes 128×(T+1)+1 single-cycle reads after the launching write.
- R3: The frame is sent MSB first: 32 ones, then a start code (01 when bit 28 = 1, 00 when bit 28 = 0), opcode bits 27:26, port bits 25:21, register/device bits 20:16, turnaround 10, and data bits 15:0.
- R4: Read frames are bit 28 = 1 with opcode 10, or bit 28 = 0 with opcode 10 or 11. On a read frame the output enable is low from frame bit 46 (first turnaround bit) to the end. All other frames drive all 64 bits.
- R5: On a read frame the master samples frame bits 48..63 at clock rising edges 49..64, each sample taken L system clocks later (L = bits 22:20, with L no greater than T). At frame end status bits 15:0 hold the 16 samples MSB first and bit 16 is set.
- R6: Write and address frames leave status bits 15:0 unchanged.
- R7: Data register bit 23 selects the drive edge. With 0, frame bit k is presented from falling edge k (or from launch, for k = 0) until falling edge k+1. With 1, bit k is changed on rising edge k+1 and is held through falling edge k+1.
- R8: A write to offset 0x0 while a frame is in progress is ignored. The ongoing frame's bits and length are unchanged, the stored command fields read back unchanged, and no second frame follows.
- R9: A write to offset 0x4 updates bits 31:20 at any time and reads back at once. The current frame keeps the settings it latched at launch.
- R10: While idle the management clock is low and the output enable is low.
- R11: A write to offset 0x0 with bit 31 clear, made while idle, stores bits 28:0 for readback without launching. Control readback is {busy, 00, bits 28:0}. Read data appears one clock after the read strobe. Other offsets read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 32 | Host read data, valid the clock after bus_rd |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Management data line, output enable |

## Verification
The bench builds the block with its default parameters, so the reset threshold of 4 and the 3-bit delay field are what the reset check sees. Each frame then reprograms the threshold to a value between 0 and 3. This keeps every frame under about 520 clocks while still covering the fastest divider, delays equal to the threshold, both drive edges, and both frame types with every opcode class. A responder in the bench records the line on both clock edges, so the two drive-edge settings are told apart, and returns a distinct data pattern on each read.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int CYC_W      = 6;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int DIV_W      = 8;
  localparam int LAT_W      = 3;
  localparam int PAYLOAD_W  = 16;

  typedef struct packed {
    logic                 short_fmt;
    logic [1:0]           op;
    logic [4:0]           port;
    logic [4:0]           dev;
    logic [PAYLOAD_W-1:0] payload;
  } mgmt_cmd_t;

  function automatic logic is_read_op(input mgmt_cmd_t c);
    if (c.short_fmt) return (c.op == 2'b10);
    return c.op[1];
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
    logic [1:0] st;
    st = c.short_fmt ? 2'b01 : 2'b00;
    return {32'hFFFF_FFFF, st, c.op, c.port, c.dev, 2'b10, c.payload};
  endfunction

  // Frame bit currently on the line, given completed clock periods,
  // clock phase and the drive-edge selection.
  function automatic logic [CYC_W-1:0] line_index(input logic [CYC_W-1:0] cyc,
                                                  input logic mdc_hi,
                                                  input logic rise_drive);
    if (!rise_drive || mdc_hi) return cyc;
    if (cyc == '0) return '0;
    return cyc - 1'b1;
  endfunction

endpackage

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
#(
  parameter logic [31:0]      CTRL_OFS = 32'h0,
  parameter logic [31:0]      DATA_OFS = 32'h4,
  parameter logic [DIV_W-1:0] DIV_RST  = 8'd4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  input  logic                 busy,
  input  logic [PAYLOAD_W-1:0] rd_data,
  output logic                 start,
  output logic                 ctrl_drop,
  output mgmt_cmd_t            launch_cmd,
  output mgmt_cmd_t            cmd,
  output logic [DIV_W-1:0]     div_set,
  output logic                 edge_set,
  output logic [LAT_W-1:0]     lat_set
);

  localparam int PAD_W = 32 - DIV_W - 1 - LAT_W - 1 - PAYLOAD_W;

  logic ctrl_hit, data_hit;
  logic unused_wbits;

  assign ctrl_hit     = bus_wr && (bus_addr == CTRL_OFS);
  assign data_hit     = bus_wr && (bus_addr == DATA_OFS);
  assign launch_cmd   = mgmt_cmd_t'(bus_wdata[28:0]);
  assign start        = ctrl_hit && !busy && bus_wdata[31];
  assign ctrl_drop    = ctrl_hit && busy;
  assign unused_wbits = ^{bus_wdata[30:29], bus_wdata[31-DIV_W-1-LAT_W:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= '0;
      div_set  <= DIV_RST;
      edge_set <= 1'b0;
      lat_set  <= '0;
    end else begin
      if (ctrl_hit && !busy) cmd <= launch_cmd;
      if (data_hit) begin
        div_set  <= bus_wdata[31 -: DIV_W];
        edge_set <= bus_wdata[31-DIV_W];
        lat_set  <= bus_wdata[31-DIV_W-1 -: LAT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == CTRL_OFS)
        bus_rdata <= {busy, 2'b00, cmd};
      else if (bus_addr == DATA_OFS)
        bus_rdata <= {div_set, edge_set, lat_set, {PAD_W{1'b0}}, !busy, rd_data};
      else
        bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);

  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick    = run && (cnt == div);
  assign rise_ev = tick && !mdc;
  assign fall_ev = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  mgmt_cmd_t            launch_cmd,
  input  logic [DIV_W-1:0]     div_set,
  input  logic                 edge_set,
  input  logic [LAT_W-1:0]     lat_set,
  input  logic                 mdc,
  input  logic                 rise_ev,
  input  logic                 fall_ev,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic [DIV_W-1:0]     div_act,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [PAYLOAD_W-1:0] rd_data,
  output logic                 frame_done,
  output logic                 cap_ev
);

  localparam int                PEND_W   = (1 << LAT_W) - 1;
  localparam logic [CYC_W-1:0]  LAST_CYC = CYC_W'(FRAME_BITS - 1);
  localparam logic [CYC_W-1:0]  TA_IDX   = CYC_W'(TA_POS);
  localparam logic [CYC_W-1:0]  DAT_IDX  = CYC_W'(DATA_POS);

  logic [FRAME_BITS-1:0] frame_q;
  logic [CYC_W-1:0]      cyc_q;
  logic [CYC_W-1:0]      idx;
  logic                  rd_flag;
  logic                  edge_q;
  logic [LAT_W-1:0]      lat_q;
  logic [PEND_W-1:0]     pend;
  logic [PAYLOAD_W-1:0]  rsh;
  logic                  rise_data;

  assign idx        = line_index(cyc_q, mdc, edge_q);
  assign frame_done = busy && fall_ev && (cyc_q == LAST_CYC);
  assign rise_data  = busy && rise_ev && rd_flag && (cyc_q >= DAT_IDX);
  assign cap_ev     = (lat_q == '0) ? rise_data : pend[lat_q - 1'b1];
  assign mdio_o     = busy ? frame_q[LAST_CYC - idx] : 1'b1;
  assign mdio_oe    = busy && !(rd_flag && (idx >= TA_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cyc_q   <= '0;
      frame_q <= '0;
      rd_flag <= 1'b0;
      edge_q  <= 1'b0;
      lat_q   <= '0;
      div_act <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cyc_q   <= '0;
      frame_q <= build_frame(launch_cmd);
      rd_flag <= is_read_op(launch_cmd);
      edge_q  <= edge_set;
      lat_q   <= lat_set;
      div_act <= div_set;
    end else if (busy && fall_ev) begin
      if (cyc_q == LAST_CYC) busy <= 1'b0;
      else                   cyc_q <= cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      rsh     <= '0;
      rd_data <= '0;
    end else begin
      pend <= {pend[PEND_W-2:0], rise_data};
      if (cap_ev) rsh <= {rsh[PAYLOAD_W-2:0], mdio_i};
      if (frame_done && rd_flag) rd_data <= rsh;
    end
  end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RST = 8'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);

  logic                 busy, start, ctrl_drop, frame_done, cap_ev;
  logic                 rise_ev, fall_ev;
  mgmt_cmd_t            launch_cmd, cmd;
  logic [DIV_W-1:0]     div_set, div_act;
  logic                 edge_set;
  logic [LAT_W-1:0]     lat_set;
  logic [PAYLOAD_W-1:0] rd_data;

  mdio_host_regs #(.DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .busy(busy), .rd_data(rd_data),
    .start(start), .ctrl_drop(ctrl_drop), .launch_cmd(launch_cmd), .cmd(cmd),
    .div_set(div_set), .edge_set(edge_set), .lat_set(lat_set)
  );

  mdio_mdc_gen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_act),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .launch_cmd(launch_cmd),
    .div_set(div_set), .edge_set(edge_set), .lat_set(lat_set),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
    .busy(busy), .div_act(div_act), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data), .frame_done(frame_done), .cap_ev(cap_ev)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        start,
  input logic        ctrl_drop,
  input logic        frame_done,
  input logic        rise_ev,
  input logic        fall_ev,
  input logic        cap_ev,
  input logic [28:0] cmd_bits
);

  p_mdc_low_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_oe_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !mdc));

  p_done_clears_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  p_rise_goes_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> mdc);

  p_fall_goes_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !mdc);

  p_drop_keeps_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_drop && !frame_done) |=> (busy && $stable(cmd_bits)));

  p_capture_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |-> busy);

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_oe(mdio_oe),
  .start(start), .ctrl_drop(ctrl_drop), .frame_done(frame_done),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .cap_ev(cap_ev), .cmd_bits(cmd)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mdio_mgmt_master dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // Vector: {short[56], op[55:54], port[53:49], reg[48:44], data[43:28],
  //          thr[27:20], edge[19], lat[18:16], responder value[15:0]}
  localparam logic [56:0] VECS [0:5] = '{
    {1'b1, 2'b10, 5'h01, 5'h02, 16'h0000, 8'd1, 1'b0, 3'd0, 16'hA5C3},
    {1'b1, 2'b01, 5'h1F, 5'h00, 16'hBEEF, 8'd0, 1'b0, 3'd0, 16'h0000},
    {1'b0, 2'b00, 5'h03, 5'h1E, 16'h1234, 8'd2, 1'b1, 3'd0, 16'hFFFF},
    {1'b0, 2'b11, 5'h03, 5'h1E, 16'h0000, 8'd2, 1'b0, 3'd2, 16'h0F0F},
    {1'b0, 2'b10, 5'h10, 5'h01, 16'h0000, 8'd3, 1'b1, 3'd3, 16'h8001},
    {1'b0, 2'b01, 5'h00, 5'h1F, 16'h5A5A, 8'd1, 1'b1, 3'd1, 16'h0000}
  };

  // Responder: records the line before each clock edge, returns read data.
  int          nr = 0, nf = 0;
  logic        rise_o [64];
  logic        fall_o [64];
  logic        fall_oe [64];
  logic [15:0] rsp_val = '0;
  logic        prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (nr < 64) rise_o[nr] = prev_o;
      nr = nr + 1;
    end
    if (!mdc && prev_mdc) begin
      if (nf < 64) begin
        fall_o[nf]  = prev_o;
        fall_oe[nf] = prev_oe;
      end
      nf = nf + 1;
      if (nf >= 48 && nf <= 63) mdio_i = rsp_val[15 - (nf - 48)];
      else if (nf == 47)        mdio_i = 1'b0;
      else                      mdio_i = 1'b1;
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
    prev_oe  = mdio_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
  end

  // Launch one frame and poll until the busy bit clears.
  task automatic run_frame(input logic [56:0] v, input bit inject, output int cyc);
    logic [31:0] r;
    bit done;
    bus_write(32'h4, {v[27:20], v[19], v[18:16], 20'h0});
    nr = 0; nf = 0; rsp_val = v[15:0]; mdio_i = 1'b1;
    bus_write(32'h0, {1'b1, 2'b00, v[56:28]});
    cyc = 0; done = 0;
    while (!done && cyc < 3000) begin
      cyc++;
      if (inject && cyc == 50)
        bus_write(32'h0, {1'b1, 2'b00, 1'b0, 2'b11, 5'h0A, 5'h0B, 16'hFFFF});
      else if (inject && cyc == 51)
        bus_write(32'h4, 32'h0000_0000);
      else begin
        bus_read(32'h0, r);
        if (!r[31]) done = 1;
      end
    end
  endtask

  // Compare the recorded line against the frame the bench expects.
  task automatic check_frame(input logic [56:0] v);
    logic [63:0] e;
    logic        rd, edg;
    int          n, bad_f, bad_r, bad_oe;
    edg = v[19];
    rd  = v[56] ? (v[55:54] == 2'b10) : v[55];
    e   = {32'hFFFF_FFFF, (v[56] ? 2'b01 : 2'b00), v[55:44], 2'b10, v[43:28]};
    n   = rd ? 46 : 64;
    bad_f = -1; bad_r = -1; bad_oe = -1;
    for (int i = 0; i < n; i++) begin
      if (bad_f < 0 && fall_o[i] !== e[63-i]) bad_f = i;
      if (bad_r < 0 && rise_o[i] !== ((edg && i > 0) ? e[64-i] : e[63-i])) bad_r = i;
    end
    for (int i = 0; i < 64; i++)
      if (bad_oe < 0 && fall_oe[i] !== (rd ? (i < 46) : 1'b1)) bad_oe = i;
    chk("R3 frame bit first mismatch", 64'(bad_f), 64'(-1));
    chk("R7 line before rising edges", 64'(bad_r), 64'(-1));
    chk("R4 output enable mismatch index", 64'(bad_oe), 64'(-1));
    chk("R2 rising edge count", 64'(nr), 64'd64);
  endtask

  initial begin
    logic [31:0] r;
    logic [15:0] last_rd;
    int          cyc;
    last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    bus_read(32'h0, r); chk("R1 control after reset", r, 32'h0000_0000);
    bus_read(32'h4, r); chk("R1 status after reset", r, 32'h0401_0000);
    chk("R10 clock low idle", mdc, 1'b0);
    chk("R10 enable low idle", mdio_oe, 1'b0);

    // R11: unmapped offset and store without launch
    bus_write(32'h8, 32'hFFFF_FFFF);
    bus_read(32'h8, r); chk("R11 unmapped reads zero", r, 32'h0);
    bus_read(32'h4, r); chk("R11 unmapped write ignored", r, 32'h0401_0000);
    bus_write(32'h0, 32'h7ABC_DEF1);
    bus_read(32'h0, r); chk("R11 store without launch", r, 32'h1ABC_DEF1);
    repeat (20) @(negedge clk);
    chk("R11 no frame without bit 31", mdc, 1'b0);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 6; k++) begin
      logic [56:0] v;
      logic        rd;
      v  = VECS[k];
      rd = v[56] ? (v[55:54] == 2'b10) : v[55];
      run_frame(v, 1'b0, cyc);
      chk("R2 polls until busy clears", 64'(cyc), 64'(128 * (int'(v[27:20]) + 1) + 1));
      check_frame(v);
      if (rd) last_rd = v[15:0];
      bus_read(32'h4, r);
      chk(rd ? "R5 status after read" : "R6 status after write", r,
          {v[27:20], v[19], v[18:16], 4'h1, last_rd});
      bus_read(32'h0, r);
      chk("R11 control readback", r, {3'b000, v[56:28]});
      chk("R10 clock low after frame", mdc, 1'b0);
    end

    // R8 and R9: writes during a frame
    begin
      logic [56:0] v;
      v = {1'b1, 2'b01, 5'h05, 5'h06, 16'hC3A5, 8'd2, 1'b0, 3'd1, 16'h0000};
      run_frame(v, 1'b1, cyc);
      chk("R8 length unchanged by ignored write", 64'(cyc), 64'(128 * 3 + 1));
      check_frame(v);
      bus_read(32'h0, r);
      chk("R8 command fields kept", r, {3'b000, v[56:28]});
      bus_read(32'h4, r);
      chk("R9 settings written mid-frame", r, {8'd0, 1'b0, 3'd0, 4'h1, last_rd});
      repeat (30) @(negedge clk);
      chk("R8 no second frame", mdc, 1'b0);
      bus_read(32'h0, r);
      chk("R8 still idle", r[31], 1'b0);
    end

    summary();
  end

endmodule